// File: doc/BRIEF.md
# FEC Codeword Framer for 66-bit Line Blocks

This block sits between the 64b/66b coding layer and the physical medium attachment. It takes 66-bit line blocks through a valid/ready handshake and builds one forward-error-correction codeword at a time. Each codeword is a fixed synchronization pattern, then a fixed number of payload blocks, then sixteen parity bytes. All of it leaves as a stream of 66-bit words, most significant bit first, with flags on the first and last word of each codeword.

The parity bytes come from a neighbouring systematic encoder. That encoder observes the accepted input blocks at the handshake. The framer asks it for bytes over a request/valid port and only orders and times the fields. Two parameters choose the layout:

| Layout | Blocks | Sync bits | Total bits |
|---|---|---|---|
| Long, full 2-bit headers | 28 | 40 | 2016 |
| Short, full 2-bit headers | 25 | 22 | 1800 |
| Long, 1-bit header per block | 29 | 17 | 2030 |
| Short, 1-bit header per block | 25 | 22 | 1775 |

The input is held off while the sync and parity fields go out, so the input rate follows the line-rate expansion. A bit accumulator repacks the fields into output words. The last word of a codeword is filled with zeros.

Top module: `fec_cw_framer`

## Requirements
- R1: Each codeword is emitted MSB first as the sync field, then the payload blocks in the order they were accepted, then the parity bytes in the order they arrived. Each block goes out from bit 65 downward, and each parity byte from bit 7 downward.
- R2: With the long layout and full headers (the defaults), a codeword holds 40 sync bits, 28 blocks of 66 bits and 128 parity bits. That is 2016 bits, sent as 31 output words.
- R3: With the short layout and 1-bit headers, each block is sent as its bit 65 followed by bits 63..0, and bit 64 is dropped. A codeword then holds 22 sync bits, 25 blocks of 65 bits and 128 parity bits. That is 1775 bits, sent as 27 output words.
- R4: `in_ready` is high only while payload blocks are being collected. A block offered while `in_ready` is low is not taken and does not appear in the output.
- R5: `par_req` rises only in the cycle after the last payload block is accepted. It stays high until 16 bytes have been taken with `par_vld`.
- R6: `out_sof` marks only the first word of a codeword and `out_eof` marks only its last word. Neither flag is ever high without `out_vld`.
- R7: Bit positions of the final word that lie past the end of the codeword are zero.
- R8: During reset, `out_vld`, `in_ready` and `par_req` are low.
- R9: After the last word of a codeword, the next codeword starts again with the sync field. The cycle after an `out_eof` word carries no output word.
- R10: The sync field is the low N bits of the `SYNC_PAT` parameter, sent from bit N-1 downward. N is 40, 22 or 17 depending on the layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 66 | Line block; bits 65..64 are the header |
| in_valid | input | 1 | Input block is valid |
| in_ready | output | 1 | Framer accepts a block this cycle |
| par_req | output | 1 | Framer wants parity bytes |
| par_vld | input | 1 | Parity byte is valid and is taken this cycle |
| par_data | input | 8 | Parity byte |
| out_word | output | 66 | Output word, MSB sent first |
| out_vld | output | 1 | Output word is valid |
| out_sof | output | 1 | First word of a codeword |
| out_eof | output | 1 | Last word of a codeword |

## Verification
A wrong fill count in the accumulator shifts every later bit. That shows as a content mismatch within one or two words of the fault and as a wrong word count at `out_eof`. A sequencer that leaves the payload phase too early or too late changes the field boundaries and moves `par_req` away from the cycle after the last accepted block, which is visible within one cycle. A stale start flag or a missed flush shows at the codeword edges as misplaced `out_sof`/`out_eof` or as non-zero padding bits.

// File: rtl/fecf_pkg.sv
// Package: shared constants, state type and layout functions for the
// codeword framer. Assumes 66-bit line blocks and 16 parity bytes.
package fecf_pkg;

    localparam int WORD_W    = 66;          // line block and output word width
    localparam int ACC_W     = 2 * WORD_W;  // accumulator depth in bits
    localparam int CNT_W     = $clog2(ACC_W + 1);
    localparam int SYNC_MAX  = 40;          // longest sync field
    localparam int PAR_BYTES = 16;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_PAY   = 2'd1,
        ST_PAR   = 2'd2,
        ST_FLUSH = 2'd3
    } fecf_state_e;

    // Number of payload blocks for a layout
    function automatic int fecf_nblk(input int long_lay, input int hdr1);
        if (long_lay != 0) return (hdr1 != 0) ? 29 : 28;
        return 25;
    endfunction

    // Sync field length for a layout
    function automatic int fecf_sync_len(input int long_lay, input int hdr1);
        if (long_lay != 0) return (hdr1 != 0) ? 17 : 40;
        return 22;
    endfunction

    // Bits sent per payload block
    function automatic int fecf_blk_len(input int hdr1);
        return (hdr1 != 0) ? WORD_W - 1 : WORD_W;
    endfunction

endpackage

// File: rtl/fecf_gearbox.sv
// Bit accumulator: takes right-justified fields of up to one word and
// emits 66-bit words oldest bit first. Assumes the caller pushes only
// when the fill after this cycle's take fits in ACC_W bits. A pad take
// left-justifies the remaining bits and zero-fills the rest.
module fecf_gearbox
    import fecf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [CNT_W-1:0]  push_len,
    input  logic [WORD_W-1:0] push_data,
    input  logic              take,
    input  logic              pad,
    input  logic              tag_sof,
    input  logic              tag_eof,
    output logic [CNT_W-1:0]  fill,
    output logic [WORD_W-1:0] out_word,
    output logic              out_vld,
    output logic              out_sof,
    output logic              out_eof
);

    logic [ACC_W-1:0]  acc_q, acc_nxt;
    logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_nxt;
    logic [WORD_W-1:0] word_full, word_pad;

    assign fill = cnt_q;

    // Select the outgoing word and compute the next fill and contents
    always_comb begin
        word_full = WORD_W'(acc_q >> (cnt_q - CNT_W'(WORD_W)));
        word_pad  = WORD_W'(acc_q << (CNT_W'(WORD_W) - cnt_q));
        if (!take)    cnt_mid = cnt_q;
        else if (pad) cnt_mid = '0;
        else          cnt_mid = cnt_q - CNT_W'(WORD_W);
        acc_nxt = acc_q;
        cnt_nxt = cnt_mid;
        if (push_en) begin
            acc_nxt = (acc_q << push_len) | ACC_W'(push_data);
            cnt_nxt = cnt_mid + push_len;
        end
    end

    // Accumulator and fill register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Registered output word and its flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_vld  <= 1'b0;
            out_sof  <= 1'b0;
            out_eof  <= 1'b0;
        end else begin
            out_vld  <= take;
            out_sof  <= take & tag_sof;
            out_eof  <= take & tag_eof;
            if (take) out_word <= pad ? word_pad : word_full;
        end
    end

endmodule

// File: rtl/fecf_seq.sv
// Field sequencer: walks sync, payload, parity and flush phases and
// tells the accumulator what to push and when to emit. Assumes the
// accumulator fill is at least 8 bits on entering flush, which holds
// because the last parity byte is pushed just before flush.
module fecf_seq
    import fecf_pkg::*;
#(
    parameter int                  NBLK     = 28,
    parameter int                  SYNC_LEN = 40,
    parameter int                  HDR1     = 0,
    parameter logic [SYNC_MAX-1:0] SYNC_PAT = 40'hB5_3C_E1_96_4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              par_req,
    input  logic              par_vld,
    input  logic [BYTE_W-1:0] par_data,
    input  logic [CNT_W-1:0]  fill,
    output logic              push_en,
    output logic [CNT_W-1:0]  push_len,
    output logic [WORD_W-1:0] push_data,
    output logic              take,
    output logic              pad,
    output logic              tag_sof,
    output logic              tag_eof
);

    localparam int BLK_LEN = fecf_blk_len(HDR1);
    localparam int BC_W    = $clog2(NBLK + 1);
    localparam int PC_W    = $clog2(PAR_BYTES + 1);
    localparam logic [SYNC_MAX-1:0] SYNC_MASK = (SYNC_MAX'(1) << SYNC_LEN) - SYNC_MAX'(1);

    fecf_state_e       state_q;
    logic [BC_W-1:0]   blk_q;
    logic [PC_W-1:0]   byte_q;
    logic              sof_pend_q;
    logic [WORD_W-1:0] blk_bits;

    // Block bits as sent: full header, or header reduced to bit 65
    generate
        if (HDR1 != 0) begin : g_hdr1
            assign blk_bits = {1'b0, in_data[WORD_W-1], in_data[WORD_W-3:0]};
        end else begin : g_hdr2
            assign blk_bits = in_data;
        end
    endgenerate

    assign in_ready = (state_q == ST_PAY);
    assign par_req  = (state_q == ST_PAR);
    assign take     = (fill >= CNT_W'(WORD_W)) || (state_q == ST_FLUSH);
    assign pad      = (state_q == ST_FLUSH) && (fill <= CNT_W'(WORD_W));
    assign tag_sof  = sof_pend_q;
    assign tag_eof  = pad;

    // Choose the field pushed into the accumulator this cycle
    always_comb begin
        push_en   = 1'b0;
        push_len  = '0;
        push_data = '0;
        case (state_q)
            ST_SYNC: begin
                push_en   = 1'b1;
                push_len  = CNT_W'(SYNC_LEN);
                push_data = WORD_W'(SYNC_PAT & SYNC_MASK);
            end
            ST_PAY: begin
                push_en   = in_valid;
                push_len  = CNT_W'(BLK_LEN);
                push_data = blk_bits;
            end
            ST_PAR: begin
                push_en   = par_vld;
                push_len  = CNT_W'(BYTE_W);
                push_data = WORD_W'(par_data);
            end
            default: ;
        endcase
    end

    // Phase state and field counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            blk_q   <= '0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                ST_SYNC: begin
                    state_q <= ST_PAY;
                    blk_q   <= '0;
                end
                ST_PAY: if (in_valid) begin
                    if (blk_q == BC_W'(NBLK - 1)) begin
                        state_q <= ST_PAR;
                        byte_q  <= '0;
                    end else begin
                        blk_q <= blk_q + 1'b1;
                    end
                end
                ST_PAR: if (par_vld) begin
                    if (byte_q == PC_W'(PAR_BYTES - 1)) state_q <= ST_FLUSH;
                    else                                byte_q  <= byte_q + 1'b1;
                end
                default: if (fill <= CNT_W'(WORD_W)) state_q <= ST_SYNC;
            endcase
        end
    end

    // Remember that the next emitted word opens a codeword
    always_ff @(posedge clk) begin
        if (!rst_n)                  sof_pend_q <= 1'b0;
        else if (state_q == ST_SYNC) sof_pend_q <= 1'b1;
        else if (take)               sof_pend_q <= 1'b0;
    end

endmodule

// File: rtl/fec_cw_framer.sv
// Top: FEC codeword framer for 66-bit line blocks. LONG_LAYOUT picks the
// long or short codeword, HDR1 reduces each block header to one bit.
// Assumes the parity source observes accepted input blocks itself.
module fec_cw_framer
    import fecf_pkg::*;
#(
    parameter int                  LONG_LAYOUT = 1,
    parameter int                  HDR1        = 0,
    parameter logic [SYNC_MAX-1:0] SYNC_PAT    = 40'hB5_3C_E1_96_4D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [65:0]  in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic         par_req,
    input  logic         par_vld,
    input  logic [7:0]   par_data,
    output logic [65:0]  out_word,
    output logic         out_vld,
    output logic         out_sof,
    output logic         out_eof
);

    localparam int NBLK     = fecf_nblk(LONG_LAYOUT, HDR1);
    localparam int SYNC_LEN = fecf_sync_len(LONG_LAYOUT, HDR1);

    logic [CNT_W-1:0]  fill;
    logic              push_en, take, pad, tag_sof, tag_eof;
    logic [CNT_W-1:0]  push_len;
    logic [WORD_W-1:0] push_data;

    fecf_seq #(
        .NBLK     (NBLK),
        .SYNC_LEN (SYNC_LEN),
        .HDR1     (HDR1),
        .SYNC_PAT (SYNC_PAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .par_req   (par_req),
        .par_vld   (par_vld),
        .par_data  (par_data),
        .fill      (fill),
        .push_en   (push_en),
        .push_len  (push_len),
        .push_data (push_data),
        .take      (take),
        .pad       (pad),
        .tag_sof   (tag_sof),
        .tag_eof   (tag_eof)
    );

    fecf_gearbox u_gbx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_len  (push_len),
        .push_data (push_data),
        .take      (take),
        .pad       (pad),
        .tag_sof   (tag_sof),
        .tag_eof   (tag_eof),
        .fill      (fill),
        .out_word  (out_word),
        .out_vld   (out_vld),
        .out_sof   (out_sof),
        .out_eof   (out_eof)
    );

endmodule

// File: rtl/fecf_chk.sv
// Checker: port-level timing properties of the codeword framer.
// Attached to every framer instance by the bind below.
module fecf_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic par_req,
    input logic par_vld,
    input logic out_vld,
    input logic out_sof,
    input logic out_eof
);

    AST_PAR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_req) |-> $past(in_valid && in_ready)); // R5

    AST_PAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (par_req && !par_vld) |=> par_req); // R5

    AST_PAR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        par_req |-> !in_ready); // R4

    AST_FLAGS_NEED_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (!out_sof && !out_eof)); // R6

    AST_SOF_NOT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !(out_sof && out_eof)); // R6

    AST_GAP_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_eof) |=> !out_vld); // R9

endmodule

bind fec_cw_framer fecf_chk u_fecf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .par_req  (par_req),
    .par_vld  (par_vld),
    .out_vld  (out_vld),
    .out_sof  (out_sof),
    .out_eof  (out_eof)
);

// File: tb/tb_fec_cw_framer.sv
// Directed bench: instance dut uses the default layout, instance dut_b
// uses the short layout with 1-bit headers. Each task runs one scenario.
module tb_fec_cw_framer;

    localparam logic [39:0] SYNC = 40'hB5_3C_E1_96_4D;
    localparam int MAXW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [65:0] in_data  [2];
    logic        in_valid [2];
    logic        in_ready [2];
    logic        par_req  [2];
    logic        par_vld  [2];
    logic [7:0]  par_data [2];
    logic [65:0] out_word [2];
    logic        out_vld  [2];
    logic        out_sof  [2];
    logic        out_eof  [2];

    fec_cw_framer #(.LONG_LAYOUT(1), .HDR1(0), .SYNC_PAT(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data[0]), .in_valid(in_valid[0]),
        .in_ready(in_ready[0]), .par_req(par_req[0]), .par_vld(par_vld[0]),
        .par_data(par_data[0]), .out_word(out_word[0]), .out_vld(out_vld[0]),
        .out_sof(out_sof[0]), .out_eof(out_eof[0]));

    fec_cw_framer #(.LONG_LAYOUT(0), .HDR1(1), .SYNC_PAT(SYNC)) dut_b (
        .clk(clk), .rst_n(rst_n), .in_data(in_data[1]), .in_valid(in_valid[1]),
        .in_ready(in_ready[1]), .par_req(par_req[1]), .par_vld(par_vld[1]),
        .par_data(par_data[1]), .out_word(out_word[1]), .out_vld(out_vld[1]),
        .out_sof(out_sof[1]), .out_eof(out_eof[1]));

    // Layout constants taken from the requirements (R2, R3, R10)
    int nblk [2]  = '{28, 25};
    int slen [2]  = '{40, 22};
    int hdr1 [2]  = '{0, 1};
    int nbits [2] = '{2016, 1775};
    int nwrd [2]  = '{31, 27};

    int checks = 0;
    int errors = 0;

    // Capture state
    logic [65:0] cap_w [2][MAXW];
    bit          cap_s [2][MAXW];
    bit          cap_e [2][MAXW];
    int          nw    [2];
    bit          eof_seen [2];
    int          pdly  [2];
    int          pseed [2];
    int          pidx  [2];
    int          pwait [2];
    int          hs_cnt [2];
    int          viol4 [2];
    int          viol5 [2];
    bit          expb [0:MAXW*66-1];

    function automatic logic [65:0] mkblk(input int seed, input int b);
        logic [1:0] h;
        h = (b % 3 == 0) ? 2'b10 : 2'b01;
        return {h, 32'(seed * 7919 + b * 40503), 32'(~(seed ^ (b << 8)))};
    endfunction

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 5);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [65:0] got, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Output capture and handshake monitors, all at the falling edge
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && out_vld[k]) begin
                if (nw[k] < MAXW) begin
                    cap_w[k][nw[k]] = out_word[k];
                    cap_s[k][nw[k]] = out_sof[k];
                    cap_e[k][nw[k]] = out_eof[k];
                end
                nw[k]++;
                if (out_eof[k]) eof_seen[k] = 1'b1;
            end
            if (rst_n && par_req[k] && in_ready[k]) viol4[k]++;
            if (rst_n && par_req[k] && hs_cnt[k] != nblk[k]) viol5[k]++;
            if (rst_n && in_valid[k] && in_ready[k]) hs_cnt[k]++;
        end
    end

    // Parity source: answers requests after pdly idle cycles per byte
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && par_req[k] && pwait[k] >= pdly[k]) begin
                par_vld[k]  = 1'b1;
                par_data[k] = pbyte(pseed[k], pidx[k]);
                pidx[k]++;
                pwait[k] = 0;
            end else begin
                par_vld[k]  = 1'b0;
                par_data[k] = 8'h00;
                if (par_req[k]) pwait[k]++;
            end
        end
    end

    // Send one codeword on instance k and check everything at the ports
    task automatic run_cw(input int k, input int seed, input int gap,
                          input int pd, input bit junk, input string tag);
        int pos;
        int tmo;
        logic [65:0] b;
        logic [65:0] ew;
        bit ok_bits;
        bit ok_flags;
        bit ok_pad;
        @(negedge clk);
        nw[k] = 0; eof_seen[k] = 1'b0; hs_cnt[k] = 0;
        pdly[k] = pd; pseed[k] = seed; pidx[k] = 0; pwait[k] = 0;
        // expected bitstream (R1, R10)
        pos = 0;
        for (int j = 0; j < MAXW*66; j++) expb[j] = 1'b0;
        for (int j = slen[k] - 1; j >= 0; j--) begin expb[pos] = SYNC[j]; pos++; end
        for (int i = 0; i < nblk[k]; i++) begin
            b = mkblk(seed, i);
            if (hdr1[k] != 0) begin
                expb[pos] = b[65]; pos++;
                for (int j = 63; j >= 0; j--) begin expb[pos] = b[j]; pos++; end
            end else begin
                for (int j = 65; j >= 0; j--) begin expb[pos] = b[j]; pos++; end
            end
        end
        for (int i = 0; i < 16; i++)
            for (int j = 7; j >= 0; j--) begin expb[pos] = pbyte(seed, i)[j]; pos++; end
        check(pos == nbits[k], tag, "bench bit total", 66'(pos), 66'(nbits[k]));
        // drive blocks; junk is offered only while ready is low (R4)
        for (int i = 0; i < nblk[k]; i++) begin
            while (!in_ready[k]) begin
                in_valid[k] = junk;
                in_data[k]  = 66'h3_FFFF_0000_FFFF_0000;
                @(negedge clk);
            end
            in_valid[k] = 1'b1;
            in_data[k]  = mkblk(seed, i);
            @(negedge clk);
            for (int g = 0; g < gap; g++) begin
                in_valid[k] = 1'b0;
                @(negedge clk);
            end
        end
        tmo = 0;
        while (!eof_seen[k] && tmo < 2000) begin
            in_valid[k] = junk && !in_ready[k];
            in_data[k]  = 66'h3_FFFF_0000_FFFF_0000;
            @(negedge clk);
            tmo++;
        end
        in_valid[k] = 1'b0;
        @(negedge clk);
        check(nw[k] == nwrd[k], tag, "word count", 66'(nw[k]), 66'(nwrd[k]));
        ok_bits = 1'b1; ok_flags = 1'b1;
        for (int w = 0; w < nwrd[k] && w < MAXW; w++) begin
            for (int j = 0; j < 66; j++) ew[65-j] = expb[w*66 + j];
            if (cap_w[k][w] !== ew) begin
                if (ok_bits)
                    $display("FAIL R1 word %0d: got %0h expected %0h", w, cap_w[k][w], ew);
                ok_bits = 1'b0;
            end
            if (cap_s[k][w] != (w == 0) || cap_e[k][w] != (w == nwrd[k] - 1)) ok_flags = 1'b0;
        end
        check(ok_bits, "R1", "codeword content", 66'(ok_bits), 66'd1);
        check(ok_flags, "R6", "sof/eof placement", 66'(ok_flags), 66'd1);
        ok_pad = 1'b1;
        for (int j = nbits[k]; j < nwrd[k]*66; j++)
            if (cap_w[k][nwrd[k]-1][65 - (j - (nwrd[k]-1)*66)] !== 1'b0) ok_pad = 1'b0;
        check(ok_pad, "R7", "zero padding", cap_w[k][nwrd[k]-1], 66'd0);
        check(viol4[k] == 0, "R4", "ready during parity", 66'(viol4[k]), 66'd0);
        check(viol5[k] == 0, "R5", "early parity request", 66'(viol5[k]), 66'd0);
        check(pidx[k] == 16, "R5", "parity bytes taken", 66'(pidx[k]), 66'd16);
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(out_vld[k] == 1'b0, "R8", "out_vld in reset", 66'(out_vld[k]), 66'd0);
            check(in_ready[k] == 1'b0, "R8", "in_ready in reset", 66'(in_ready[k]), 66'd0);
            check(par_req[k] == 1'b0, "R8", "par_req in reset", 66'(par_req[k]), 66'd0);
        end
    endtask

    // R2: long layout, no stalls
    task automatic t_long_plain;
        run_cw(0, 1, 0, 0, 1'b0, "R2");
    endtask

    // R4/R5: gaps, slow parity, junk offered while not ready
    task automatic t_long_stalls;
        run_cw(0, 2, 2, 3, 1'b1, "R2");
    endtask

    // R3: short layout with 1-bit headers
    task automatic t_short_hdr1;
        run_cw(1, 3, 1, 1, 1'b1, "R3");
    endtask

    // R9: consecutive codewords each restart with sync
    task automatic t_back_to_back;
        run_cw(0, 4, 0, 0, 1'b0, "R9");
        run_cw(0, 5, 0, 0, 1'b1, "R9");
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            in_data[k] = '0; in_valid[k] = 1'b0; par_vld[k] = 1'b0; par_data[k] = '0;
            nw[k] = 0; eof_seen[k] = 1'b0; pdly[k] = 0; pseed[k] = 0; pidx[k] = 0;
            pwait[k] = 0; hs_cnt[k] = 0; viol4[k] = 0; viol5[k] = 0;
        end
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_long_plain();
        t_long_stalls();
        t_short_hdr1();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule